// File: doc/BRIEF.md
# Asynchronous SRAM Page-Mode Read Controller

This block sits between a synchronous request port and an external asynchronous static RAM that holds 262,144 words of 16 bits. A requester offers a word address, write data, a two-bit byte mask, a read/write flag and a burst length using a valid/ready handshake. The controller then drives the memory's chip-enable pair, write strobe, output enable, the two byte-lane enables, the 18-bit address and the control for a tristate data bus. Every wait interval is a whole number of clock cycles, computed from a clock-period parameter.

A write is one long write-strobe access. A read takes from one to sixteen words. The first word, and the first word after the address moves into the next 16-word page, waits a full random-access cycle. The remaining words keep the page address (bits 17:4) open, change only bits 3:0, and wait only the shorter output-enable access time. This keeps the memory in its low-current page mode. Each word read back arrives with a one-cycle valid strobe.

Top module: `asram_page_ctrl`

## Requirements
- R1: While no operation is in progress the controller holds the memory in standby (`mem_ce1_n`=1, `mem_ce2`=0), keeps `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0, and holds `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the operation has finished.
- R3: A write selects the chip (`mem_ce1_n`=0, `mem_ce2`=1) and holds `mem_we_n`=0 for at least ceil(T_RC/period) cycles. During that time `mem_dq_oe`=1, `mem_dq_out` carries the request data and `mem_oe_n` stays 1.
- R4: Mask bit 0 drives `mem_lb_n` low, which covers data bits 7:0. Mask bit 1 drives `mem_ub_n` low, which covers bits 15:8. This holds for both reads and writes. A write with mask 00 changes no stored byte.
- R5: On a read, `mem_oe_n` is 0 and the address stays unchanged for at least ceil(T_RC/period) cycles up to and including the first `rd_valid` cycle. `rd_data` equals the memory bus in that cycle.
- R6: A read of length L returns L words from consecutive addresses. A length of 0 counts as 1, and a length above 16 counts as 16. Between words in the same page, bits 17:4 stay the same, bits 3:0 increase by one, and each such word waits at least ceil(T_OE/period) cycles.
- R7: When the next word starts a new 16-word page, the new address is applied and held for a full ceil(T_RC/period) wait before its `rd_valid`.
- R8: `mem_dq_oe` is 0 in the clock cycle before any cycle in which `mem_oe_n` goes from 1 to 0.
- R9: Each wait count is the ceiling of time divided by the clock period, and never less than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes, bit 0 = low byte, bit 1 = high byte |
| req_len | input | 5 | Read burst length in words |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 16 | Read word |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_addr | output | 18 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data bus as seen from the memory |

## Verification
The assertions assume a few things about the inputs:
- Requests are held stable while `req_valid` waits for `req_ready`.
- `mem_dq_in` only reflects what the memory returns.
- Read lengths fit the five-bit field.

The stimulus changes inputs only on falling edges and holds each request until it is accepted. Its memory model returns data only when the chip is selected with the output enable low and the write strobe high, and it drives zero on disabled byte lanes. Addresses are chosen so that bursts start both aligned and unaligned to a page, and one burst crosses a page boundary.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_OPEN  = 2'd2,
    ST_PAGE  = 2'd3
  } ctl_state_e;

  // Ceiling of time / clock period, never below one cycle (R9).
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Burst length normalisation: 0 -> 1, above page size -> page size (R6).
  function automatic int unsigned norm_len(input int unsigned len,
                                           input int unsigned page_words);
    if (len == 0) return 1;
    if (len > page_words) return page_words;
    return len;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_addr_gen.sv
module asram_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_in_page
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= load_addr;
    else if (step)  addr_q <= addr_q + 1'b1;
  end

  assign addr         = addr_q;
  assign last_in_page = &addr_q[PAGE_W-1:0];
endmodule

// File: rtl/asram_page_ctrl.sv
module asram_page_ctrl #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 70,
  parameter int T_OE_NS       = 25,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int PAGE_W        = 4,
  parameter int LEN_W         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_bmask,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  import asram_pkg::*;

  localparam int unsigned RC_CYC     = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned OE_CYC     = ns_to_cycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC    = (RC_CYC > OE_CYC) ? RC_CYC : OE_CYC;
  localparam int          CNT_W      = $clog2(MAX_CYC) + 1;
  localparam int unsigned PAGE_WORDS = 1 << PAGE_W;

  ctl_state_e        st_q, st_d;
  logic [LEN_W-1:0]  rem_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q;

  // Named internal events
  logic accept;
  logic in_read;
  logic beat_done;
  logic more_beats;
  logic tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic tmr_done;
  logic addr_step;
  logic last_in_page;
  logic [ADDR_W-1:0] addr;

  assign accept     = req_valid && (st_q == ST_IDLE);
  assign in_read    = (st_q == ST_OPEN) || (st_q == ST_PAGE);
  assign beat_done  = in_read && tmr_done;
  assign more_beats = (rem_q > LEN_W'(1));
  assign addr_step  = beat_done && more_beats;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(RC_CYC - 1);
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        st_d     = req_write ? ST_WRITE : ST_OPEN;
      end
      ST_WRITE: if (tmr_done) st_d = ST_IDLE;
      ST_OPEN, ST_PAGE: if (tmr_done) begin
        if (!more_beats) st_d = ST_IDLE;
        else begin
          tmr_load = 1'b1;
          if (last_in_page) begin
            st_d    = ST_OPEN;
            tmr_val = CNT_W'(RC_CYC - 1);
          end else begin
            st_d    = ST_PAGE;
            tmr_val = CNT_W'(OE_CYC - 1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        rem_q   <= LEN_W'(norm_len(int'(req_len), PAGE_WORDS));
        wdata_q <= req_wdata;
        mask_q  <= req_bmask;
      end else if (addr_step) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_addr    (req_addr),
    .step         (addr_step),
    .addr         (addr),
    .last_in_page (last_in_page)
  );

  // Memory-side decode
  logic sel;
  assign sel        = (st_q != ST_IDLE);
  assign mem_ce1_n  = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = (st_q != ST_WRITE);
  assign mem_oe_n   = !in_read;
  assign mem_dq_oe  = (st_q == ST_WRITE);
  assign mem_dq_out = wdata_q;
  assign mem_lb_n   = !(sel && mask_q[0]);
  assign mem_ub_n   = !(sel && mask_q[1]);
  assign mem_addr   = addr;
  assign req_ready  = (st_q == ST_IDLE);
  assign rd_valid   = beat_done;
  assign rd_data    = mem_dq_in;

  // Independent window counters for the assertions
  logic [15:0] open_cnt_q;
  logic [15:0] wr_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_cnt_q <= '0;
      wr_cnt_q   <= '0;
    end else begin
      open_cnt_q <= (!mem_oe_n && !rd_valid) ? open_cnt_q + 1'b1 : '0;
      wr_cnt_q   <= (!mem_we_n) ? wr_cnt_q + 1'b1 : '0;
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dq_oe && mem_we_n && mem_oe_n));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_write_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2));

  p_write_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($past(wr_cnt_q) >= 16'(RC_CYC - 1)));

  p_open_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && st_q == ST_OPEN) |-> (open_cnt_q == 16'(RC_CYC - 1)));

  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_valid) && st_q == ST_PAGE) |->
      (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]) &&
       mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + 1'b1));

  p_page_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_valid) && st_q == ST_OPEN) |-> ($past(mem_addr[PAGE_W-1:0]) == '1));

  p_bus_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

// File: tb/asram_page_ctrl_tb.sv
module asram_page_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int RC_W   = (70 + CLK_NS - 1) / CLK_NS;            // R9 ceiling
  localparam int OE_W0  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int OE_W   = (OE_W0 < 1) ? 1 : OE_W0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic [4:0]  req_len = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic        ce1_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [17:0] maddr;
  logic [15:0] dq_out, dq_in;

  asram_page_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .req_len(req_len), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_ce1_n(ce1_n), .mem_ce2(ce2), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_ub_n(ub_n), .mem_lb_n(lb_n), .mem_addr(maddr),
    .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
  );

  // Memory model: 1024 words, aliased on address bits 9:0
  logic [15:0] sram [1024];
  logic [15:0] shadow [1024];
  initial for (int i = 0; i < 1024; i++) begin sram[i] = '0; shadow[i] = '0; end

  logic sel_ok;
  assign sel_ok = !ce1_n && ce2;
  assign dq_in = (sel_ok && we_n && !oe_n) ?
                 {ub_n ? 8'h00 : sram[maddr[9:0]][15:8],
                  lb_n ? 8'h00 : sram[maddr[9:0]][7:0]} : 16'h0000;

  always @(posedge clk) if (sel_ok && !we_n) begin
    if (!lb_n) sram[maddr[9:0]][7:0]  <= dq_out[7:0];
    if (!ub_n) sram[maddr[9:0]][15:8] <= dq_out[15:8];
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  typedef struct { logic [17:0] a; logic [15:0] d; int minw; } item_t;
  item_t exp_q[$];

  // Driver
  task automatic send(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m, input logic [4:0] len);
    int n;
    if (wr) begin
      if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
    end else begin
      n = (len == 0) ? 1 : ((len > 16) ? 16 : int'(len));
      for (int i = 0; i < n; i++) begin
        item_t it;
        it.a = a + 18'(i);
        it.d = shadow[it.a[9:0]] & {{8{m[1]}}, {8{m[0]}}};
        it.minw = (i == 0 || it.a[3:0] == 4'h0) ? RC_W : OE_W;
        exp_q.push_back(it);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_bmask = m; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
  endtask

  // Monitor / scoreboard
  int          stab = 0, wlen = 0;
  logic        p_oe_n = 1'b1, p_we_n = 1'b1, p_dqoe = 1'b0;
  logic [17:0] p_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (!oe_n) stab = (!p_oe_n && maddr == p_addr) ? stab + 1 : 1;
    else       stab = 0;
    if (!oe_n && p_oe_n)
      chk(p_dqoe == 1'b0, "R8", "dq_oe before oe fall", p_dqoe, 0);
    if (!we_n) begin
      wlen++;
      chk(oe_n && dq_oe, "R3", "oe_n/dq_oe during write", {oe_n, dq_oe}, 3);
    end
    if (we_n && !p_we_n) begin
      chk(wlen >= RC_W, "R3", "write strobe cycles", wlen, RC_W);
      wlen = 0;
    end
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected rd_valid", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(rd_data == it.d, "R4/R5", "read data", rd_data, it.d);
        chk(maddr == it.a, "R6", "beat address", maddr, it.a);
        chk(stab >= it.minw, (it.minw == RC_W) ? "R7" : "R6", "wait cycles", stab, it.minw);
      end
    end
    p_oe_n = oe_n; p_we_n = we_n; p_dqoe = dq_oe; p_addr = maddr;
  end

  // Watchdog
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe && req_ready, "R1", "idle outputs",
        {ce1_n, ce2, we_n, oe_n, dq_oe, req_ready}, 6'b101101);
    // R3 single write and R5 single read back
    send(1, 18'h2_0010, 16'hA55A, 2'b11, 5'd1);
    send(0, 18'h2_0010, 16'h0, 2'b11, 5'd1);
    // R4 byte lanes
    send(1, 18'h0_0011, 16'h1234, 2'b11, 5'd1);
    send(1, 18'h0_0011, 16'hFFCD, 2'b01, 5'd1);
    send(1, 18'h0_0011, 16'hEFFF, 2'b10, 5'd1);
    send(0, 18'h0_0011, 16'h0, 2'b11, 5'd1);
    send(1, 18'h0_0011, 16'h0000, 2'b00, 5'd1);   // R4 mask 00 leaves data
    send(0, 18'h0_0011, 16'h0, 2'b11, 5'd1);
    send(0, 18'h0_0011, 16'h0, 2'b01, 5'd1);      // R4 low lane only
    // R6 aligned burst of 16
    for (int i = 0; i < 16; i++) send(1, 18'h1_0020 + 18'(i), 16'h3000 + 16'(i * 7), 2'b11, 5'd1);
    send(0, 18'h1_0020, 16'h0, 2'b11, 5'd16);
    // R7 burst crossing a page
    for (int i = 0; i < 8; i++) send(1, 18'h0_003C + 18'(i), 16'hC000 + 16'(i), 2'b11, 5'd1);
    send(0, 18'h0_003C, 16'h0, 2'b11, 5'd8);
    // R6 length 0 and length above 16
    send(0, 18'h0_003D, 16'h0, 2'b11, 5'd0);
    send(0, 18'h1_0021, 16'h0, 2'b10, 5'd20);
    // Wait for completion
    while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ce1_n && !ce2 && !dq_oe, "R1", "standby after traffic", {ce1_n, ce2, dq_oe}, 3'b100);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule